// File: doc/BRIEF.md
# Four-Phase Handshake Protocol Monitor

This block watches a return-to-zero request/acknowledge pair on a clock and reports any ordering that breaks the four-phase handshake. Both signals are taken as already synchronous to the clock. A phase tracker follows each handshake through its four steps. The handshake starts from a quiet cycle with both signals low. The request then goes up, and the acknowledge joins it. The request then drops. The handshake ends when both signals are low again.

Every violation produces a one-cycle error pulse and a code that names the kind of violation. After an error the monitor stops judging until both signals have returned low, then it re-arms. Each legal handshake produces a one-cycle completion pulse. The current phase is exported for debug. The block sits beside a link as a passive observer and drives nothing back onto it.

Top module: `hs4_monitor`

## Requirements
- R1: While `rst_n` is low, `phase` is 0 (idle) and `err`, `err_code` and `done` are 0; activity on `req`/`ack` during reset raises no error. Reset takes effect without a clock edge, and its release is synchronised over two clock edges.
- R2: Phase encoding is idle=0, request-raised=1, both-high=2, request-released=3, recover=4. The monitor samples the inputs on each rising edge, and `phase` shows the updated value after that edge. From idle, `req`=1 with `ack`=0 moves to 1. In phase 1, `ack`=1 moves to 2. In phase 2, `req`=0 with `ack`=1 moves to 3. A phase holds while its own input pattern holds.
- R3: `done` pulses for exactly one cycle after the edge that samples `req`=0 and `ack`=0 in phase 2 or phase 3. That same edge returns `phase` to 0.
- R4: In idle, a sampled `ack`=1 (with or without `req`) gives an `err` pulse with `err_code`=1 (acknowledge without request).
- R5: In phase 1, a sampled `req`=0 gives an `err` pulse with `err_code`=2 (request withdrawn before acknowledge).
- R6: In phase 2, `req`=1 with `ack`=0 gives an `err` pulse with `err_code`=3 (acknowledge dropped while request held).
- R7: In phase 3, a sampled `req`=1 gives an `err` pulse with `err_code`=4 (request raised again before acknowledge returned low).
- R8: Every error moves the monitor to phase 4. In phase 4, input changes raise neither `err` nor `done`. The first sampled `req`=0, `ack`=0 returns the monitor to idle. `err` lasts one cycle, and `err_code` is 0 whenever `err` is 0.
- R9: `err` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req | input | 1 | Observed request, already synchronous |
| ack | input | 1 | Observed acknowledge, already synchronous |
| err | output | 1 | One-cycle protocol violation pulse |
| err_code | output | 3 | Violation kind while `err` is high, else 0 |
| done | output | 1 | One-cycle pulse per completed handshake |
| phase | output | 3 | Current tracking phase, for debug |

## Verification
The bench targets the ordering corners where a monitor is easily wrong:
- Both signals falling in the same cycle from phase 2 is a legal completion. A design that demands a separate release phase would flag it as an error instead.
- Both signals rising together from idle must be reported as an acknowledge without a request. A design that tests `req` first would treat it as a normal start.
- Within the same handshake, `ack` dropping early and `req` re-rising late must be told apart by their codes. Swapping the code per phase would show up as wrong `err_code` values.
- After a violation, further activity must stay silent until both signals are low. A monitor that re-arms early would give a cascade of extra errors.
- A reset in the middle of a handshake must bring the phase back to idle at once.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

  localparam int PHASE_W = 3;
  localparam int CODE_W  = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE    = 3'd0,
    PH_REQ     = 3'd1,
    PH_BOTH    = 3'd2,
    PH_REL     = 3'd3,
    PH_RECOVER = 3'd4
  } hs_phase_e;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE           = 3'd0,
    EC_ACK_NO_REQ     = 3'd1,
    EC_REQ_WITHDRAWN  = 3'd2,
    EC_ACK_EARLY_DROP = 3'd3,
    EC_REQ_REASSERT   = 3'd4
  } hs_err_e;

  typedef struct packed {
    logic req;
    logic ack;
  } hs_pair_t;

endpackage

// File: rtl/hs4_rst_sync.sv
module hs4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  // asserted at once, released after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/hs4_classify.sv
module hs4_classify
  import hs4_pkg::*;
(
  input  hs_phase_e phase_cur,
  input  hs_pair_t  smp,
  output hs_phase_e phase_nxt,
  output hs_err_e   code_nxt,
  output logic      done_nxt
);
  always_comb begin
    phase_nxt = phase_cur;
    code_nxt  = EC_NONE;
    done_nxt  = 1'b0;
    unique case (phase_cur)
      PH_IDLE: begin
        if (smp.ack) begin
          phase_nxt = PH_RECOVER;
          code_nxt  = EC_ACK_NO_REQ;
        end else if (smp.req) begin
          phase_nxt = PH_REQ;
        end
      end
      PH_REQ: begin
        if (!smp.req) begin
          phase_nxt = PH_RECOVER;
          code_nxt  = EC_REQ_WITHDRAWN;
        end else if (smp.ack) begin
          phase_nxt = PH_BOTH;
        end
      end
      PH_BOTH: begin
        if (smp.req && !smp.ack) begin
          phase_nxt = PH_RECOVER;
          code_nxt  = EC_ACK_EARLY_DROP;
        end else if (!smp.req && smp.ack) begin
          phase_nxt = PH_REL;
        end else if (!smp.req && !smp.ack) begin
          phase_nxt = PH_IDLE;
          done_nxt  = 1'b1;
        end
      end
      PH_REL: begin
        if (smp.req) begin
          phase_nxt = PH_RECOVER;
          code_nxt  = EC_REQ_REASSERT;
        end else if (!smp.ack) begin
          phase_nxt = PH_IDLE;
          done_nxt  = 1'b1;
        end
      end
      PH_RECOVER: begin
        if (!smp.req && !smp.ack) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_RECOVER;
    endcase
  end
endmodule

// File: rtl/hs4_state_reg.sv
module hs4_state_reg
  import hs4_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_phase_e phase_nxt,
  input  hs_err_e   code_nxt,
  input  logic      done_nxt,
  output hs_phase_e phase_q,
  output hs_err_e   code_q,
  output logic      err_q,
  output logic      done_q
);
  logic phase_en;
  assign phase_en = (phase_nxt != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= PH_IDLE;
    else if (phase_en) phase_q <= phase_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= EC_NONE;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      code_q <= code_nxt;
      err_q  <= (code_nxt != EC_NONE);
      done_q <= done_nxt;
    end
  end
endmodule

// File: rtl/hs4_monitor.sv
module hs4_monitor
  import hs4_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              ack,
  output logic              err,
  output logic [CODE_W-1:0] err_code,
  output logic              done,
  output logic [PHASE_W-1:0] phase
);
  logic      rst_core_n;
  hs_pair_t  smp;
  hs_phase_e phase_cur, phase_nxt;
  hs_err_e   code_nxt, code_cur;
  logic      done_nxt;

  assign smp = '{req: req, ack: ack};

  hs4_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  hs4_classify classify_i (
    .phase_cur (phase_cur),
    .smp       (smp),
    .phase_nxt (phase_nxt),
    .code_nxt  (code_nxt),
    .done_nxt  (done_nxt)
  );

  hs4_state_reg state_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .phase_nxt (phase_nxt),
    .code_nxt  (code_nxt),
    .done_nxt  (done_nxt),
    .phase_q   (phase_cur),
    .code_q    (code_cur),
    .err_q     (err),
    .done_q    (done)
  );

  assign err_code = code_cur;
  assign phase    = phase_cur;
endmodule

// File: rtl/hs4_monitor_chk.sv
module hs4_monitor_chk
  import hs4_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               ack,
  input logic               err,
  input logic [CODE_W-1:0]  err_code,
  input logic               done,
  input logic [PHASE_W-1:0] phase
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (phase == PH_IDLE && !err && !done && err_code == EC_NONE));

  a_r2_start_request: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && req && !ack) |=> phase == PH_REQ);

  a_r3_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) inside {PH_BOTH, PH_REL} && !$past(req) && !$past(ack)));

  a_r4_ack_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && ack) |=> (err && err_code == EC_ACK_NO_REQ));

  a_r5_req_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REQ && !req) |=> (err && err_code == EC_REQ_WITHDRAWN));

  a_r6_ack_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BOTH && req && !ack) |=> (err && err_code == EC_ACK_EARLY_DROP));

  a_r7_req_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REL && req) |=> (err && err_code == EC_REQ_REASSERT));

  a_r8_err_to_recover: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phase == PH_RECOVER));

  a_r8_recover_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOVER) |=> (!err && !done));

  a_r8_code_tracks_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != EC_NONE) == err);

  a_r9_err_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && done));
endmodule

bind hs4_monitor hs4_monitor_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .req      (req),
  .ack      (ack),
  .err      (err),
  .err_code (err_code),
  .done     (done),
  .phase    (phase)
);

// File: tb/hs4_monitor_tb_top.sv
module hs4_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req, ack;
  logic       err, done;
  logic [2:0] err_code, phase;

  int n_chk  = 0;
  int n_fail = 0;
  bit summary_done = 1'b0;

  always #4 clk = ~clk;

  hs4_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
    .err(err), .err_code(err_code), .done(done), .phase(phase)
  );

  // vector: [9]req [8]ack [7]err [6:4]code [3]done [2:0]phase
  localparam int NV = 33;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0_000_0_000, // idle
    10'b1_0_0_000_0_001,
    10'b1_0_0_000_0_001,
    10'b1_1_0_000_0_010,
    10'b1_1_0_000_0_010,
    10'b0_1_0_000_0_011,
    10'b0_1_0_000_0_011,
    10'b0_0_0_000_1_000, // complete
    10'b1_0_0_000_0_001,
    10'b1_1_0_000_0_010,
    10'b0_0_0_000_1_000, // both fall together
    10'b0_1_1_001_0_100, // ack without req
    10'b0_1_0_000_0_100,
    10'b1_1_0_000_0_100,
    10'b0_0_0_000_0_000,
    10'b1_0_0_000_0_001,
    10'b0_0_1_010_0_100, // withdrawn
    10'b0_0_0_000_0_000,
    10'b1_0_0_000_0_001,
    10'b1_1_0_000_0_010,
    10'b1_0_1_011_0_100, // ack dropped early
    10'b1_0_0_000_0_100,
    10'b0_0_0_000_0_000,
    10'b1_0_0_000_0_001,
    10'b1_1_0_000_0_010,
    10'b0_1_0_000_0_011,
    10'b1_1_1_100_0_100, // req raised again
    10'b0_0_0_000_0_000,
    10'b1_1_1_001_0_100, // both rise from idle
    10'b0_0_0_000_0_000,
    10'b1_0_0_000_0_001,
    10'b0_1_1_010_0_100, // swap in request phase
    10'b0_0_0_000_0_000
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual err/code/done/phase=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic a);
    @(negedge clk);
    req = r;
    ack = a;
    @(posedge clk);
    #2;
  endtask

  function automatic string tag_of(input logic [7:0] e);
    if (e[7]) begin
      case (e[6:4])
        3'd1:    return "R4";
        3'd2:    return "R5";
        3'd3:    return "R6";
        default: return "R7";
      endcase
    end
    if (e[3]) return "R3";
    if (e[2:0] == 3'd4) return "R8";
    return "R2";
  endfunction

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req   = 1'b0;
    ack   = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", {err, err_code, done, 1'b0, phase}, 8'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][9], VEC[i][8]);
      check(tag_of(VEC[i][7:0]), {err, err_code, done, phase}, VEC[i][7:0]);
      check("R9 err/done exclusive", {7'b0, err & done}, 8'b0);
    end

    // mid-handshake reset
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    check("R2 both high before reset", {err, err_code, done, phase}, 8'b0_000_0_010);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset to idle", {err, err_code, done, phase}, 8'b0);
    apply(1'b0, 1'b1);
    check("R1 ack during reset ignored", {err, err_code, done, phase}, 8'b0);
    apply(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    apply(1'b1, 1'b0);
    check("R2 restart after reset", {err, err_code, done, phase}, 8'b0_000_0_001);
    apply(1'b1, 1'b1);
    apply(1'b0, 1'b0);
    check("R3 completion after reset", {err, err_code, done, phase}, 8'b0_000_1_000);
    apply(1'b0, 1'b0);
    check("R3 done lasts one cycle", {err, err_code, done, phase}, 8'b0);

    // long hold in recover, then single err only
    apply(1'b0, 1'b1);
    check("R4 ack no req again", {err, err_code, done, phase}, 8'b1_001_0_100);
    apply(1'b1, 1'b0);
    check("R8 err lasts one cycle", {err, err_code, done, phase}, 8'b0_000_0_100);
    apply(1'b0, 1'b0);
    check("R8 rearm on both low", {err, err_code, done, phase}, 8'b0);

    finish_run();
  end
endmodule